// File: doc/BRIEF.md
# Conversion Clock Prescaler

This block derives the strobes that pace an analog-to-digital converter from the system clock. It does not generate a new clock; instead it emits a one-cycle rising strobe (`tick_rise`) once per conversion-clock period and a one-cycle falling strobe (`tick_fall`) halfway through that period. Downstream sequencing logic in the same clock domain can therefore act on whole and half conversion-clock cycles. A 3-bit select input `div_sel` chooses the period, which is a power of two from 2 to 128 system cycles. The division is done by a 7-bit counter.

A small controller has two states, HOLD and RUN. The transition START (HOLD to RUN) is taken when `enable` is sampled high. The transition STOP (RUN to HOLD) is taken when `enable` is sampled low. The self-transition RESYNC (RUN to RUN) is taken when `restart` is sampled high. In HOLD, and on every RESYNC, the counter is forced to zero and the strobes are silenced. The phase of the strobes relative to a trigger event is therefore fixed.

The active ratio is captured from `div_sel` only at a counter wrap, while held, or on a restart, so a change of selection never produces a short period.

Top module: `adc_clk_prescaler`

## Requirements
- R1: After reset, `tick_rise` and `tick_fall` are both low.
- R2: While `enable` is low, no strobe is produced. In the cycle after `enable` is sampled low, both strobes are low. On re-enable, the counting starts over regardless of earlier history.
- R3: For `div_sel` = n with n from 1 to 7, `tick_rise` recurs every N = 2^n clock cycles.
- R4: `div_sel` = 0 selects the same ratio as code 1, so `tick_rise` recurs every 2 cycles.
- R5: `tick_fall` is asserted N/2 cycles after each `tick_rise`, midway through the period.
- R6: Each strobe lasts exactly one cycle, and the two strobes are never high in the same cycle.
- R7: After `enable` rises, the first `tick_rise` appears after the (N+1)th rising clock edge, counting the first edge at which `enable` is sampled high.
- R8: When `restart` is sampled high at edge R, both strobes are low after R, even if edge R would have wrapped the counter. The next `tick_fall` follows N/2 edges after R, and the next `tick_rise` follows N edges after R.
- R9: The value of `div_sel` is taken at the edge that produces a `tick_rise`, or at any edge in HOLD or on a restart. A change made between those edges leaves the current period unchanged, and the new ratio governs the period that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable; low holds the counter at zero |
| restart | input | 1 | Trigger resynchronisation request; clears the counter |
| div_sel | input | 3 | Division code, N = 2^max(code,1) |
| tick_rise | output | 1 | One-cycle strobe at the start of each conversion-clock period |
| tick_fall | output | 1 | One-cycle strobe at mid-period |

## Verification
Two situations are the hardest to reach from the ports, because each needs a precise cycle alignment.

The first is a restart that lands on exactly the edge where the counter would wrap. If restart were given lower priority than the wrap, that edge would leak a `tick_rise`. The stimulus reaches it by observing a `tick_rise`, counting N-1 more edges, and then holding `restart` for the single edge that would wrap.

The second is a selection change placed immediately after a wrap edge. The bench changes `div_sel` just after a rise is observed, so that the old ratio must still govern one full period before the new one applies.

// File: rtl/adc_prescaler_pkg.sv
package adc_prescaler_pkg;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } presc_state_e;

endpackage

// File: rtl/adc_presc_ctrl.sv
module adc_presc_ctrl
    import adc_prescaler_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic restart,
    input  logic wrap,
    output logic clr,
    output logic load_sel
);

    presc_state_e state_q;
    presc_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: START, STOP, RESYNC (stays in RUN)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: if (enable)  state_d = ST_RUN;
            ST_RUN:  if (!enable) state_d = ST_HOLD;
            default:              state_d = ST_HOLD;
        endcase
    end

    // Outputs
    always_comb begin
        clr = 1'b1;
        unique case (state_q)
            ST_HOLD: clr = 1'b1;
            ST_RUN:  clr = !enable || restart;
            default: clr = 1'b1;
        endcase
        load_sel = clr || wrap;
    end

    // R2: a low enable always lands the controller in HOLD
    p_hold_on_disable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state_q == ST_HOLD));

    // R8: restart in RUN keeps RUN but forces a clear
    p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && enable) |-> clr);

endmodule

// File: rtl/adc_presc_sel.sv
module adc_presc_sel #(
    parameter int CNT_W = 7,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] div_sel,
    output logic [SEL_W-1:0] sel_act
);

    localparam logic [SEL_W-1:0] SEL_MIN = SEL_W'(1);
    localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(CNT_W);

    logic [SEL_W-1:0] sel_clamped;

    always_comb begin
        if (div_sel < SEL_MIN) begin
            sel_clamped = SEL_MIN;
        end else if (div_sel > SEL_MAX) begin
            sel_clamped = SEL_MAX;
        end else begin
            sel_clamped = div_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_act <= SEL_MIN;
        end else if (load) begin
            sel_act <= sel_clamped;
        end
    end

    // R9: the active ratio only moves on a load
    p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(sel_act));

    // R4: code 0 never reaches the counter as a zero tap
    p_sel_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_act >= SEL_MIN) && (sel_act <= SEL_MAX));

endmodule

// File: rtl/adc_presc_count.sv
module adc_presc_count #(
    parameter int CNT_W = 7,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel_act,
    output logic             wrap,
    output logic             tick_rise,
    output logic             tick_fall
);

    localparam int NUM_CODES = 2 ** SEL_W;

    logic [CNT_W-1:0]     cnt_q;
    logic [NUM_CODES-1:0] term_hit;
    logic [NUM_CODES-1:0] half_hit;

    // One terminal/midpoint comparator per tap; codes beyond the counter width tie off
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_tap
        if (g >= 1 && g <= CNT_W) begin : g_live
            assign term_hit[g] = (cnt_q == CNT_W'((1 << g) - 1));
            assign half_hit[g] = (cnt_q == CNT_W'((1 << (g - 1)) - 1));
        end else begin : g_tie
            assign term_hit[g] = 1'b0;
            assign half_hit[g] = 1'b0;
        end
    end

    assign wrap = !clr && term_hit[sel_act];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            tick_rise <= 1'b0;
            tick_fall <= 1'b0;
        end else if (clr) begin
            cnt_q     <= '0;
            tick_rise <= 1'b0;
            tick_fall <= 1'b0;
        end else begin
            cnt_q     <= term_hit[sel_act] ? '0 : cnt_q + CNT_W'(1);
            tick_rise <= term_hit[sel_act];
            tick_fall <= half_hit[sel_act];
        end
    end

    // R6: rising and falling strobes are mutually exclusive
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_rise && tick_fall));

    // R2: a clearing cycle leaves both strobes silent
    p_clear_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!tick_rise && !tick_fall));

    // R3: a rising strobe always coincides with a counter back at zero
    p_rise_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_rise |-> (cnt_q == '0));

    // R6: a rising strobe never repeats on the next cycle
    p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_rise |=> !tick_rise);

endmodule

// File: rtl/adc_clk_prescaler.sv
module adc_clk_prescaler
    import adc_prescaler_pkg::*;
#(
    parameter int CNT_W = 7,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             restart,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick_rise,
    output logic             tick_fall
);

    logic             clr;
    logic             load_sel;
    logic             wrap;
    logic [SEL_W-1:0] sel_act;

    adc_presc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .restart  (restart),
        .wrap     (wrap),
        .clr      (clr),
        .load_sel (load_sel)
    );

    adc_presc_sel #(
        .CNT_W (CNT_W),
        .SEL_W (SEL_W)
    ) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_sel),
        .div_sel (div_sel),
        .sel_act (sel_act)
    );

    adc_presc_count #(
        .CNT_W (CNT_W),
        .SEL_W (SEL_W)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .sel_act   (sel_act),
        .wrap      (wrap),
        .tick_rise (tick_rise),
        .tick_fall (tick_fall)
    );

    // R1: strobes are quiet in the first cycle after reset release
    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!tick_rise && !tick_fall));

endmodule

// File: tb/adc_clk_prescaler_tb.sv
module adc_clk_prescaler_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WAIT_LIMIT = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       restart = 1'b0;
    logic [2:0] div_sel = 3'd0;
    logic       tick_rise;
    logic       tick_fall;

    int checks = 0;
    int errors = 0;
    bit both_seen = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_clk_prescaler dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .restart   (restart),
        .div_sel   (div_sel),
        .tick_rise (tick_rise),
        .tick_fall (tick_fall)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        if (tick_rise && tick_fall) both_seen = 1'b1;
    endtask

    task automatic wait_rise(output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (!tick_rise && n < WAIT_LIMIT);
    endtask

    task automatic wait_fall(output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (!tick_fall && n < WAIT_LIMIT);
    endtask

    function automatic int ratio(input int code);
        return (code == 0) ? 2 : (1 << code);
    endfunction

    task automatic t_reset();
        chk(tick_rise == 1'b0, "R1 rise after reset", int'(tick_rise), 0);
        chk(tick_fall == 1'b0, "R1 fall after reset", int'(tick_fall), 0);
    endtask

    task automatic t_ratio(input int code);
        int n1;
        int n2;
        int nr;
        int big_n;
        big_n = ratio(code);
        enable = 1'b0;
        div_sel = 3'(code);
        both_seen = 1'b0;
        tick();
        tick();
        enable = 1'b1;
        wait_rise(nr);
        chk(nr == big_n + 1, "R7 first rise edges", nr, big_n + 1);
        wait_fall(n1);
        chk(n1 == big_n / 2, "R5 rise-to-fall distance", n1, big_n / 2);
        wait_rise(n2);
        if (code == 0) chk(n1 + n2 == 2, "R4 code 0 period", n1 + n2, 2);
        else           chk(n1 + n2 == big_n, "R3 period", n1 + n2, big_n);
        tick();
        chk(tick_rise == 1'b0, "R6 rise one cycle wide", int'(tick_rise), 0);
        chk(both_seen == 1'b0, "R6 strobes overlapped", int'(both_seen), 0);
        enable = 1'b0;
        tick();
    endtask

    task automatic t_disable();
        int seen;
        int nr;
        div_sel = 3'd2;
        enable = 1'b1;
        wait_rise(nr);
        tick();
        enable = 1'b0;
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            tick();
            if (tick_rise || tick_fall) seen++;
        end
        chk(seen == 0, "R2 strobes while disabled", seen, 0);
        enable = 1'b1;
        wait_rise(nr);
        chk(nr == 5, "R2 count restarts on re-enable", nr, 5);
        enable = 1'b0;
        tick();
    endtask

    task automatic t_switch();
        int nr;
        div_sel = 3'd1;
        enable = 1'b1;
        wait_rise(nr);
        div_sel = 3'd3;
        wait_rise(nr);
        chk(nr == 2, "R9 old ratio finishes its period", nr, 2);
        wait_rise(nr);
        chk(nr == 8, "R9 new ratio after wrap", nr, 8);
        enable = 1'b0;
        tick();
    endtask

    task automatic t_restart_mid();
        int nr;
        int nf;
        div_sel = 3'd4;
        enable = 1'b1;
        wait_rise(nr);
        for (int i = 0; i < 5; i++) tick();
        restart = 1'b1;
        tick();
        restart = 1'b0;
        chk(!tick_rise && !tick_fall, "R8 quiet after restart",
            int'(tick_rise) + int'(tick_fall), 0);
        wait_fall(nf);
        chk(nf == 8, "R8 fall after restart", nf, 8);
        wait_rise(nr);
        chk(nf + nr == 16, "R8 rise after restart", nf + nr, 16);
        enable = 1'b0;
        tick();
    endtask

    task automatic t_restart_wrap();
        int nr;
        div_sel = 3'd2;
        enable = 1'b1;
        wait_rise(nr);
        for (int i = 0; i < 3; i++) tick();
        restart = 1'b1;
        tick();
        restart = 1'b0;
        chk(tick_rise == 1'b0, "R8 restart masks wrap", int'(tick_rise), 0);
        wait_rise(nr);
        chk(nr == 4, "R8 rise after wrap-edge restart", nr, 4);
        enable = 1'b0;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        for (int c = 0; c < 8; c++) t_ratio(c);
        t_disable();
        t_switch();
        t_restart_mid();
        t_restart_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule